// File: doc/BRIEF.md
# Interrupt Auxiliary-Register Unit

This unit sits beside the execute stage of a small 32-bit core. It handles interrupt entry and return and a small group of custom instructions. It holds four 32-bit auxiliary registers, a 32-bit mask register and a 32-bit pending register. Rising edges on the 32 interrupt lines are caught in the pending register. When interrupts are enabled, no instruction is being issued and some pending bit is not masked, the unit takes an interrupt:

- it redirects the core to a fixed handler address;
- it places the return address in auxiliary register 0;
- it places the whole set of delivered interrupt bits in auxiliary register 1, so one handler call may serve several sources.

Registers 2 and 3 are never initialized by the unit. Software uses them as scratch space.

The core hands over instructions with opcode bits [6:0] = 0001011. Such an instruction is accepted only when bits [14:12] are 000 and bits [24:20] are 00000. Bits [31:25] then pick the operation:

| Bits [31:25] | Operation |
|---|---|
| 0000000 | auxiliary read |
| 0000001 | auxiliary write |
| 0000010 | interrupt return |
| 0000011 | mask swap |
| 0000100 | wait for interrupt |

Every operation completes in the cycle it is presented, except wait, which stalls until something is pending. Each result is returned combinationally on the destination-register port.

Top module: `irq_aux_unit`

## Requirements
- R1: After reset, the mask is all ones, the pending register is zero and entry is enabled. A mask swap issued first returns 0xFFFFFFFF, and a wait issued first does not complete.
- R2: An instruction whose bits [6:0] are not 0001011, or whose bits [14:12] or [24:20] are not zero, is ignored. Done and illegal stay low, and no state changes.
- R3: An auxiliary write (bits [31:25] = 0000001) stores the rs1 value in the auxiliary register selected by instruction bits [8:7]. An auxiliary read (0000000) returns, with rd write-enable high, the register selected by bits [16:15] on rd index bits [11:7]. Both complete in the same cycle.
- R4: A mask swap (0000011) returns the old mask in rd and loads the rs1 value as the new mask. A set mask bit blocks entry for that line.
- R5: A line is latched into pending only on a rising edge. A line held high does not set pending again after its bit was cleared.
- R6: Entry is taken when entry is enabled, issue valid is low, and pending AND NOT mask is nonzero. On entry, the entry strobe is high with the entry PC equal to the VECTOR_ADDR parameter. Auxiliary register 0 receives the issue PC and auxiliary register 1 receives the delivered bits.
- R7: Entry clears only the delivered bits. Masked pending bits remain pending.
- R8: After an entry, no further entry is taken until an interrupt return executes, even while unmasked bits are pending.
- R9: An interrupt return (0000010) completes with the return strobe high, the return PC equal to auxiliary register 0, and re-enables entry.
- R10: A wait (0000100) holds done low while pending is zero. Once any pending bit is set, it completes and writes the raw pending vector to rd.
- R11: Any other value of bits [31:25] in the accepted opcode space raises illegal with done low, and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| issueValid | input | 1 | Instruction presented this cycle |
| issueInstr | input | 32 | Instruction word |
| issueRs1 | input | 32 | Value of source register 1 |
| issuePc | input | 32 | Address to resume at if entry is taken |
| irqLines | input | 32 | Interrupt request lines |
| issueDone | output | 1 | Instruction completed this cycle |
| rdWe | output | 1 | Destination register write enable |
| rdIdx | output | 5 | Destination register index |
| rdData | output | 32 | Destination register value |
| illegalInstr | output | 1 | Unknown operation in the accepted opcode space |
| entryTake | output | 1 | Interrupt entry taken this cycle |
| entryPc | output | 32 | Handler address |
| retTake | output | 1 | Interrupt return taken this cycle |
| retPc | output | 32 | Return address |

## Verification
The hardest state to reach is a pending bit that survives an entry because it was masked. Reaching it also needs entry to be blocked while new unmasked bits arrive. The stimulus first sets a mask with one line blocked. It takes a first entry, which leaves entry disabled. It then raises a masked line and an unmasked line together, checks that no entry happens, and issues a return. The second entry must deliver only the unmasked bit, and a wait must then report the masked bit still pending. A final wait stalls against lines held high, to show that levels do not re-latch, until a fresh edge arrives.

// File: rtl/irq_aux_pkg.sv
package irq_aux_pkg;
  localparam int DATA_W   = 32;
  localparam int NUM_AUX  = 4;
  localparam int AUX_IDX_W = $clog2(NUM_AUX);
  localparam int REG_IDX_W = 5;
  localparam logic [6:0] OPC_CUSTOM = 7'b0001011;

  typedef enum logic [6:0] {
    OP_AUX_RD  = 7'b0000000,
    OP_AUX_WR  = 7'b0000001,
    OP_RETURN  = 7'b0000010,
    OP_MASKSWP = 7'b0000011,
    OP_WAIT    = 7'b0000100
  } opSel_t;

  typedef enum logic [1:0] {
    SRC_AUX  = 2'd0,
    SRC_MASK = 2'd1,
    SRC_PEND = 2'd2
  } rdSrc_t;

  typedef struct packed {
    logic                 auxWe;
    logic [AUX_IDX_W-1:0] auxIdx;
    logic                 maskWe;
    logic                 enter;
    logic                 ret;
    rdSrc_t               rdSrc;
  } ctrlStrobes_t;
endpackage

// File: rtl/irq_aux_ctrl.sv
module irq_aux_ctrl
  import irq_aux_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 issueValid,
  input  logic [31:0]          issueInstr,
  input  logic [DATA_W-1:0]    pendingVec,
  input  logic [DATA_W-1:0]    maskVec,
  output logic                 issueDone,
  output logic                 rdWe,
  output logic [REG_IDX_W-1:0] rdIdx,
  output logic                 illegalInstr,
  output ctrlStrobes_t         strobes
);
  logic intEnable;
  logic inSpace;
  logic active;
  logic anyDeliverable;
  logic unusedQsHigh;

  assign inSpace = (issueInstr[6:0] == OPC_CUSTOM) && (issueInstr[14:12] == 3'b000)
                   && (issueInstr[24:20] == 5'b00000);
  assign active = issueValid && inSpace;
  assign anyDeliverable = |(pendingVec & ~maskVec);
  assign rdIdx = issueInstr[11:7];
  assign unusedQsHigh = ^issueInstr[19:17];

  always_comb begin
    strobes = '0;
    strobes.rdSrc = SRC_AUX;
    issueDone = 1'b0;
    rdWe = 1'b0;
    illegalInstr = 1'b0;
    if (active) begin
      case (issueInstr[31:25])
        OP_AUX_RD: begin
          issueDone = 1'b1;
          rdWe = 1'b1;
          strobes.auxIdx = issueInstr[16:15];
        end
        OP_AUX_WR: begin
          issueDone = 1'b1;
          strobes.auxWe = 1'b1;
          strobes.auxIdx = issueInstr[8:7];
        end
        OP_RETURN: begin
          issueDone = 1'b1;
          strobes.ret = 1'b1;
        end
        OP_MASKSWP: begin
          issueDone = 1'b1;
          rdWe = 1'b1;
          strobes.maskWe = 1'b1;
          strobes.rdSrc = SRC_MASK;
        end
        OP_WAIT: begin
          strobes.rdSrc = SRC_PEND;
          if (|pendingVec) begin
            issueDone = 1'b1;
            rdWe = 1'b1;
          end
        end
        default: illegalInstr = 1'b1;
      endcase
    end
    strobes.enter = intEnable && !issueValid && anyDeliverable;
  end

  always_ff @(posedge clk) begin
    if (!rstN) intEnable <= 1'b1;
    else if (strobes.enter) intEnable <= 1'b0;
    else if (strobes.ret) intEnable <= 1'b1;
  end

  assert_no_reentry_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.enter |=> !strobes.enter);
  assert_return_enables_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobes.ret |=> intEnable);
  assert_illegal_not_done_R11: assert property (@(posedge clk) disable iff (!rstN)
    illegalInstr |-> !issueDone && !rdWe);
  assert_wait_needs_pending_R10: assert property (@(posedge clk) disable iff (!rstN)
    (issueDone && strobes.rdSrc == SRC_PEND) |-> pendingVec != '0);
endmodule

// File: rtl/irq_aux_data.sv
module irq_aux_data
  import irq_aux_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [DATA_W-1:0] issueRs1,
  input  logic [DATA_W-1:0] issuePc,
  input  logic [DATA_W-1:0] irqLines,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] pendingVec,
  output logic [DATA_W-1:0] maskVec,
  output logic [DATA_W-1:0] retPc
);
  logic [DATA_W-1:0] auxReg [NUM_AUX];
  logic [DATA_W-1:0] irqPrev;
  logic [DATA_W-1:0] deliver;
  logic [DATA_W-1:0] rising;

  assign deliver = pendingVec & ~maskVec;
  assign rising  = irqLines & ~irqPrev;
  assign retPc   = auxReg[0];

  always_comb begin
    case (strobes.rdSrc)
      SRC_MASK: rdData = maskVec;
      SRC_PEND: rdData = pendingVec;
      default:  rdData = auxReg[strobes.auxIdx];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskVec    <= '1;
      pendingVec <= '0;
      irqPrev    <= '0;
    end else begin
      irqPrev <= irqLines;
      pendingVec <= (pendingVec & ~(strobes.enter ? deliver : '0)) | rising;
      if (strobes.maskWe) maskVec <= issueRs1;
    end
  end

  for (genvar g = 0; g < NUM_AUX; g++) begin : g_aux
    always_ff @(posedge clk) begin
      if (strobes.auxWe && strobes.auxIdx == AUX_IDX_W'(g)) auxReg[g] <= issueRs1;
      else if (strobes.enter && g == 0) auxReg[g] <= issuePc;
      else if (strobes.enter && g == 1) auxReg[g] <= deliver;
    end
  end

  assert_mask_load_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.maskWe |=> maskVec == $past(issueRs1));
  assert_entry_payload_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.enter |=> auxReg[1] != '0 && auxReg[1] == $past(deliver) && auxReg[0] == $past(issuePc));
  assert_entry_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.enter |=> (pendingVec & $past(deliver) & ~$past(rising)) == '0);
endmodule

// File: rtl/irq_aux_unit.sv
module irq_aux_unit
  import irq_aux_pkg::*;
#(
  parameter logic [31:0] VECTOR_ADDR = 32'h0000_0010
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        issueValid,
  input  logic [31:0] issueInstr,
  input  logic [31:0] issueRs1,
  input  logic [31:0] issuePc,
  input  logic [31:0] irqLines,
  output logic        issueDone,
  output logic        rdWe,
  output logic [4:0]  rdIdx,
  output logic [31:0] rdData,
  output logic        illegalInstr,
  output logic        entryTake,
  output logic [31:0] entryPc,
  output logic        retTake,
  output logic [31:0] retPc
);
  ctrlStrobes_t strobes;
  logic [DATA_W-1:0] pendingVec;
  logic [DATA_W-1:0] maskVec;

  irq_aux_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .issueInstr(issueInstr),
    .pendingVec(pendingVec), .maskVec(maskVec), .issueDone(issueDone), .rdWe(rdWe),
    .rdIdx(rdIdx), .illegalInstr(illegalInstr), .strobes(strobes)
  );

  irq_aux_data u_data (
    .clk(clk), .rstN(rstN), .strobes(strobes), .issueRs1(issueRs1), .issuePc(issuePc),
    .irqLines(irqLines), .rdData(rdData), .pendingVec(pendingVec), .maskVec(maskVec),
    .retPc(retPc)
  );

  assign entryTake = strobes.enter;
  assign entryPc   = VECTOR_ADDR;
  assign retTake   = strobes.ret;

  assert_entry_excl_issue_R6: assert property (@(posedge clk) disable iff (!rstN)
    entryTake |-> !issueValid && !issueDone);
endmodule

// File: tb/irq_aux_unit_tb.sv
module irq_aux_unit_tb;
  localparam logic [31:0] VEC = 32'h0000_0010;
  localparam int NV = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic issueValid = 1'b0;
  logic [31:0] issueInstr = '0, issueRs1 = '0, issuePc = '0, irqLines = '0;
  logic issueDone, rdWe, illegalInstr, entryTake, retTake;
  logic [4:0] rdIdx;
  logic [31:0] rdData, entryPc, retPc;

  int checks = 0;
  int errors = 0;
  logic sDone, sWe, sIll, sEntry, sRet;
  logic [4:0] sIdx;
  logic [31:0] sData, sEntryPc, sRetPc;

  always #5 clk = ~clk;

  irq_aux_unit #(.VECTOR_ADDR(VEC)) u_dut (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .issueInstr(issueInstr),
    .issueRs1(issueRs1), .issuePc(issuePc), .irqLines(irqLines), .issueDone(issueDone),
    .rdWe(rdWe), .rdIdx(rdIdx), .rdData(rdData), .illegalInstr(illegalInstr),
    .entryTake(entryTake), .entryPc(entryPc), .retTake(retTake), .retPc(retPc)
  );

  function automatic logic [31:0] enc(input logic [6:0] f7, input logic [4:0] rs1f,
                                      input logic [4:0] rdf);
    return {f7, 5'b00000, rs1f, 3'b000, rdf, 7'b0001011};
  endfunction

  localparam logic [31:0] TV_INSTR [NV] = '{
    enc(7'd3, 5'd1, 5'd5), enc(7'd3, 5'd1, 5'd6),
    enc(7'd1, 5'd10, 5'd0), enc(7'd1, 5'd10, 5'd1),
    enc(7'd1, 5'd10, 5'd2), enc(7'd1, 5'd10, 5'd3),
    enc(7'd0, 5'd2, 5'd7), enc(7'd0, 5'd0, 5'd8)};
  localparam logic [31:0] TV_RS1 [NV] = '{
    32'hFFFF0000, 32'h00000000, 32'h11111111, 32'h22222222,
    32'h33333333, 32'h44444444, 32'h0, 32'h0};
  localparam logic TV_WE [NV] = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1};
  localparam logic [31:0] TV_DATA [NV] = '{
    32'hFFFFFFFF, 32'hFFFF0000, 32'h0, 32'h0, 32'h0, 32'h0, 32'h33333333, 32'h11111111};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic sample();
    sDone = issueDone; sWe = rdWe; sIdx = rdIdx; sData = rdData; sIll = illegalInstr;
    sEntry = entryTake; sEntryPc = entryPc; sRet = retTake; sRetPc = retPc;
  endtask

  task automatic issue(input logic [31:0] ins, input logic [31:0] rs1);
    @(negedge clk);
    issueValid = 1'b1; issueInstr = ins; issueRs1 = rs1;
    #2 sample();
  endtask

  task automatic idle(input logic [31:0] lines);
    @(negedge clk);
    issueValid = 1'b0; irqLines = lines; issuePc = 32'h0000_0100;
    #2 sample();
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    idle(32'h0);
    chk("R1 no entry after reset", {31'b0, sEntry}, 32'h0);
    issue(enc(7'd4, 5'd0, 5'd3), 32'h0);
    chk("R1 wait stalls with empty pending", {31'b0, sDone}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      issue(TV_INSTR[i], TV_RS1[i]);
      chk("R3/R4/R1 table done", {31'b0, sDone}, 32'h1);
      chk("R3/R4 table rdWe", {31'b0, sWe}, {31'b0, TV_WE[i]});
      if (TV_WE[i]) begin
        chk("R3/R4/R1 table rdData", sData, TV_DATA[i]);
        chk("R3 table rdIdx", {27'b0, sIdx}, {27'b0, TV_INSTR[i][11:7]});
      end
    end

    issue(enc(7'd5, 5'd1, 5'd1), 32'hFFFFFFFF);
    chk("R11 illegal raised", {31'b0, sIll}, 32'h1);
    chk("R11 illegal not done", {31'b0, sDone}, 32'h0);
    issue({7'd3, 5'd0, 5'd1, 3'b000, 5'd1, 7'b0110011}, 32'h0000AAAA);
    chk("R2 other opcode ignored", {30'b0, sDone, sIll}, 32'h0);
    issue({7'd3, 5'd4, 5'd1, 3'b000, 5'd1, 7'b0001011}, 32'h00005555);
    chk("R2 nonzero rs2 field ignored", {30'b0, sDone, sIll}, 32'h0);
    issue(enc(7'd3, 5'd1, 5'd1), 32'h0);
    chk("R2/R11 mask unchanged", sData, 32'h0);

    idle(32'h9);
    chk("R5 edge not yet latched", {31'b0, sEntry}, 32'h0);
    idle(32'h9);
    chk("R6 entry taken", {31'b0, sEntry}, 32'h1);
    chk("R6 entry pc", sEntryPc, VEC);
    issue(enc(7'd0, 5'd1, 5'd4), 32'h0);
    chk("R6 aux1 holds delivered bits", sData, 32'h9);
    issue(enc(7'd0, 5'd0, 5'd4), 32'h0);
    chk("R6 aux0 holds return pc", sData, 32'h100);
    issue(enc(7'd0, 5'd2, 5'd4), 32'h0);
    chk("R3 aux2 untouched by entry", sData, 32'h33333333);
    issue(enc(7'd3, 5'd1, 5'd1), 32'h2);
    chk("R4 swap returns old mask", sData, 32'h0);

    idle(32'hF);
    idle(32'hF);
    chk("R8 no entry while disabled", {31'b0, sEntry}, 32'h0);
    issue(enc(7'd2, 5'd0, 5'd0), 32'h0);
    chk("R9 return strobe", {31'b0, sRet}, 32'h1);
    chk("R9 return pc", sRetPc, 32'h100);
    idle(32'hF);
    chk("R9 entry re-enabled", {31'b0, sEntry}, 32'h1);
    idle(32'hF);
    chk("R8 single entry", {31'b0, sEntry}, 32'h0);
    issue(enc(7'd0, 5'd1, 5'd4), 32'h0);
    chk("R4/R7 only unmasked bit delivered", sData, 32'h4);
    issue(enc(7'd4, 5'd0, 5'd9), 32'h0);
    chk("R10 wait done with pending", {31'b0, sDone}, 32'h1);
    chk("R7 masked bit still pending", sData, 32'h2);

    issue(enc(7'd3, 5'd1, 5'd1), 32'h0);
    chk("R4 swap returns mask", sData, 32'h2);
    issue(enc(7'd2, 5'd0, 5'd0), 32'h0);
    idle(32'hF);
    chk("R6 entry for formerly masked bit", {31'b0, sEntry}, 32'h1);
    issue(enc(7'd0, 5'd1, 5'd4), 32'h0);
    chk("R6 delivered formerly masked bit", sData, 32'h2);

    issue(enc(7'd4, 5'd0, 5'd12), 32'h0);
    chk("R5/R10 held lines do not relatch", {31'b0, sDone}, 32'h0);
    issue(enc(7'd4, 5'd0, 5'd12), 32'h0);
    chk("R10 wait still stalled", {30'b0, sDone, sWe}, 32'h0);
    irqLines = 32'h2F;
    issue(enc(7'd4, 5'd0, 5'd12), 32'h0);
    chk("R10 wait completes", {31'b0, sDone}, 32'h1);
    chk("R10 wait returns pending", sData, 32'h20);
    chk("R10 wait rd index", {27'b0, sIdx}, 32'd12);
    idle(32'h2F);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule